// File: doc/BRIEF.md
# Fetch Target Predictor with Return Address Stack

This block sits in the instruction fetch stage. Each cycle it is given the fetch address, and in the same cycle it answers two questions. Is this address a branch it has seen taken before? If so, which address should be fetched next? The answer comes from a direct-mapped table. Each table slot records a tag, the taken target and a flag that marks return instructions. A slot is used only when its stored tag matches the fetch address. A slot whose tag does not match counts as no branch.

A separate direction predictor supplies the taken or not-taken decision on an input. Resolved taken branches write the table through an update port. Call and return notifications from the pipeline push onto and pop from a small circular return address stack. Returns that hit in the table are redirected to the top of that stack. When a return hits and the stack is empty, the target stored in the table is used instead.

The next fetch address is produced combinationally from the current table and stack contents. Updates to the table and the stack take effect from the following cycle.

Top module: `fetch_target_pred`

## Requirements
- R1: After reset every table slot is invalid and the stack is empty. Any lookup then gives lk_hit=0 and next_pc=lk_pc+4, and ras_valid=0.
- R2: An update with upd_en=1 writes slot upd_pc[7:2] (with 64 slots) at the clock edge. From the next cycle on, a lookup of the same address gives lk_hit=1 and lk_target=upd_target. A later update to the same slot replaces it.
- R3: The tag is made of the address bits above the index together with bits [1:0]. A lookup that shares an index with a stored entry but differs in any tag bit gives lk_hit=0 and next_pc=lk_pc+4.
- R4: On a hit whose return flag is clear, next_pc is lk_target when lk_taken=1 and lk_pc+4 when lk_taken=0.
- R5: On a hit whose return flag is set, with ras_valid=1, next_pc is ras_top and lk_is_ret=1. This holds whatever the value of lk_taken.
- R6: On a hit whose return flag is set, with the stack empty, next_pc is the stored lk_target.
- R7: An update in the same cycle as a lookup of the same slot leaves that lookup with the old slot contents.
- R8: A push alone (call_push=1, ret_pop=0) makes ras_top equal call_addr and sets ras_valid. A pop alone on a non-empty stack exposes the previous entry. Entries come back last in, first out.
- R9: The stack holds 8 entries. A push onto a full stack overwrites the oldest entry. After 9 pushes, 8 pops return the 8 newest values, newest first, and the stack is then empty.
- R10: A pop alone on an empty stack has no effect. The stack stays empty, and a following push and pop behave normally.
- R11: A push and a pop in the same cycle on a non-empty stack replace the top with call_addr and keep the depth unchanged. On an empty stack the pair acts as a push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | 32 | Fetch address being looked up |
| lk_taken | input | 1 | Taken decision from the direction predictor |
| lk_hit | output | 1 | Valid entry with matching tag |
| lk_is_ret | output | 1 | Hit entry is marked as a return |
| lk_target | output | 32 | Target stored in the addressed slot |
| next_pc | output | 32 | Predicted next fetch address |
| upd_en | input | 1 | Write a resolved taken branch |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_target | input | 32 | Its taken target |
| upd_is_ret | input | 1 | Resolved branch is a return |
| call_push | input | 1 | A call was fetched; push its return address |
| call_addr | input | 32 | Return address to push |
| ret_pop | input | 1 | A return was fetched; pop the stack |
| ras_top | output | 32 | Top of the return address stack |
| ras_valid | output | 1 | Stack holds at least one entry |

## Verification
The assertions assume that call_push, ret_pop and upd_en are never unknown once reset is released. They also assume that lk_pc may change every cycle independently of updates. The bench drives every input on the falling edge and holds lk_pc at a fixed, known address when it checks that an update has landed. This keeps the comparisons one cycle apart from the write that caused them. Push and pop pairs are issued only in defined combinations, so the stack depth is always known to the bench.

// File: rtl/fetch_target_pred.sv
module fetch_target_pred #(
  parameter int ADDR_W    = 32,
  parameter int ENTRIES   = 64,
  parameter int RAS_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_pc,
  input  logic              lk_taken,
  output logic              lk_hit,
  output logic              lk_is_ret,
  output logic [ADDR_W-1:0] lk_target,
  output logic [ADDR_W-1:0] next_pc,
  input  logic              upd_en,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic [ADDR_W-1:0] upd_target,
  input  logic              upd_is_ret,
  input  logic              call_push,
  input  logic [ADDR_W-1:0] call_addr,
  input  logic              ret_pop,
  output logic [ADDR_W-1:0] ras_top,
  output logic              ras_valid
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int SP_W  = $clog2(RAS_DEPTH);
  localparam int CNT_W = $clog2(RAS_DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(RAS_DEPTH);

  logic [ENTRIES-1:0] vld;
  logic [ENTRIES-1:0] retf;
  logic [TAG_W-1:0]   tagm [ENTRIES];
  logic [ADDR_W-1:0]  tgtm [ENTRIES];

  wire [IDX_W-1:0] ridx = lk_pc[IDX_W+1:2];
  wire [IDX_W-1:0] widx = upd_pc[IDX_W+1:2];
  wire [TAG_W-1:0] rtag = {lk_pc[ADDR_W-1:IDX_W+2], lk_pc[1:0]};
  wire [TAG_W-1:0] wtag = {upd_pc[ADDR_W-1:IDX_W+2], upd_pc[1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) vld <= '0;
    else if (upd_en) vld[widx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (upd_en) begin
      tagm[widx] <= wtag;
      tgtm[widx] <= upd_target;
      retf[widx] <= upd_is_ret;
    end
  end

  assign lk_hit    = vld[ridx] && (tagm[ridx] == rtag);
  assign lk_is_ret = lk_hit && retf[ridx];
  assign lk_target = tgtm[ridx];

  logic [ADDR_W-1:0] stk [RAS_DEPTH];
  logic [SP_W-1:0]   sp;
  logic [CNT_W-1:0]  cnt;

  wire [SP_W-1:0] top_sp  = sp - 1'b1;
  wire            nonempt = (cnt != '0);
  wire            replace = call_push && ret_pop && nonempt;
  wire            do_push = call_push && !replace;
  wire            do_pop  = ret_pop && !call_push && nonempt;
  wire [SP_W-1:0] wslot   = replace ? top_sp : sp;

  always_ff @(posedge clk) begin
    if (call_push) stk[wslot] <= call_addr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp  <= '0;
      cnt <= '0;
    end else if (do_push) begin
      sp  <= sp + 1'b1;
      cnt <= (cnt == FULL) ? cnt : cnt + 1'b1;
    end else if (do_pop) begin
      sp  <= top_sp;
      cnt <= cnt - 1'b1;
    end
  end

  assign ras_top   = stk[top_sp];
  assign ras_valid = nonempt;

  always_comb begin
    next_pc = lk_pc + ADDR_W'(4);
    if (lk_is_ret)
      next_pc = ras_valid ? ras_top : lk_target;
    else if (lk_hit && lk_taken)
      next_pc = lk_target;
  end
endmodule

module fetch_target_pred_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] lk_pc,
  input logic              lk_hit,
  input logic              lk_is_ret,
  input logic [ADDR_W-1:0] next_pc,
  input logic              upd_en,
  input logic [ADDR_W-1:0] upd_pc,
  input logic              call_push,
  input logic [ADDR_W-1:0] call_addr,
  input logic              ret_pop,
  input logic [ADDR_W-1:0] ras_top,
  input logic              ras_valid
);
  // R3
  miss_falls_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> next_pc == lk_pc + ADDR_W'(4));
  // R2
  update_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (lk_pc != $past(upd_pc)) || lk_hit);
  // R5
  return_uses_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_is_ret && ras_valid) |-> next_pc == ras_top);
  // R8
  push_sets_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_push && !ret_pop) |=> ras_valid && ras_top == $past(call_addr));
  // R10
  empty_pop_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_pop && !call_push && !ras_valid) |=> !ras_valid);
  // R11
  swap_keeps_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_push && ret_pop) |=> ras_valid && ras_top == $past(call_addr));
endmodule

bind fetch_target_pred fetch_target_pred_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_fetch_target_pred.sv
module sim_fetch_target_pred;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        lk_taken = 1'b0;
  logic        lk_hit, lk_is_ret, ras_valid;
  logic [31:0] lk_target, next_pc, ras_top;
  logic        upd_en = 1'b0, upd_is_ret = 1'b0, call_push = 1'b0, ret_pop = 1'b0;
  logic [31:0] upd_pc = '0, upd_target = '0, call_addr = '0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fetch_target_pred u0 (.*);

  // {pc, taken, expected hit, expected next_pc}
  localparam logic [65:0] VEC [6] = '{
    {32'h0000_0104, 1'b1, 1'b1, 32'h0000_3000},   // R4 taken
    {32'h0000_0104, 1'b0, 1'b1, 32'h0000_0108},   // R4 not taken
    {32'h0000_0204, 1'b1, 1'b0, 32'h0000_0208},   // R3 upper tag differs
    {32'h0000_0105, 1'b1, 1'b0, 32'h0000_0109},   // R3 low bits differ
    {32'h0000_0208, 1'b0, 1'b1, 32'h0000_4000},   // R6 return, empty stack
    {32'h0000_0300, 1'b1, 1'b0, 32'h0000_0304}    // R3 untouched slot
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic look(input logic [31:0] pc, input logic tk);
    @(negedge clk);
    lk_pc = pc;
    lk_taken = tk;
    #1;
  endtask

  task automatic wr(input logic [31:0] pc, input logic [31:0] tg, input logic r);
    @(negedge clk);
    upd_en = 1'b1; upd_pc = pc; upd_target = tg; upd_is_ret = r;
    @(posedge clk); #1;
    upd_en = 1'b0;
  endtask

  task automatic stack(input logic p, input logic q, input logic [31:0] a);
    @(negedge clk);
    call_push = p; ret_pop = q; call_addr = a;
    @(posedge clk); #1;
    call_push = 1'b0; ret_pop = 1'b0;
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    look(32'h0000_0104, 1'b1);
    chk("R1 hit after reset", {31'b0, lk_hit}, 32'd0);
    chk("R1 next_pc after reset", next_pc, 32'h0000_0108);
    chk("R1 stack empty", {31'b0, ras_valid}, 32'd0);

    wr(32'h0000_0104, 32'h0000_3000, 1'b0);
    wr(32'h0000_0208, 32'h0000_4000, 1'b1);
    look(32'h0000_0104, 1'b1);
    chk("R2 target stored", lk_target, 32'h0000_3000);

    foreach (VEC[i]) begin
      look(VEC[i][65:34], VEC[i][33]);
      chk($sformatf("R3/R4/R6 vector %0d hit", i), {31'b0, lk_hit}, {31'b0, VEC[i][32]});
      chk($sformatf("R3/R4/R6 vector %0d next_pc", i), next_pc, VEC[i][31:0]);
    end

    // R7: same-cycle update of the slot under lookup
    @(negedge clk);
    lk_pc = 32'h0000_0104; lk_taken = 1'b1;
    upd_en = 1'b1; upd_pc = 32'h0000_0104; upd_target = 32'h0000_5000; upd_is_ret = 1'b0;
    #1;
    chk("R7 old contents during write", next_pc, 32'h0000_3000);
    @(posedge clk); #1;
    upd_en = 1'b0;
    chk("R2 overwrite visible next cycle", next_pc, 32'h0000_5000);

    // R8 LIFO
    stack(1'b1, 1'b0, 32'h0000_0010);
    stack(1'b1, 1'b0, 32'h0000_0020);
    chk("R8 top after two pushes", ras_top, 32'h0000_0020);
    look(32'h0000_0208, 1'b0);
    chk("R5 return uses stack", next_pc, 32'h0000_0020);
    chk("R5 return flag", {31'b0, lk_is_ret}, 32'd1);
    stack(1'b0, 1'b1, '0);
    chk("R8 top after pop", ras_top, 32'h0000_0010);
    stack(1'b0, 1'b1, '0);
    chk("R8 empty after pops", {31'b0, ras_valid}, 32'd0);

    // R10 pop on empty
    stack(1'b0, 1'b1, '0);
    chk("R10 still empty", {31'b0, ras_valid}, 32'd0);
    stack(1'b1, 1'b0, 32'h0000_0030);
    chk("R10 push after empty pop", ras_top, 32'h0000_0030);

    // R11 push and pop together
    stack(1'b1, 1'b1, 32'h0000_0040);
    chk("R11 top replaced", ras_top, 32'h0000_0040);
    stack(1'b0, 1'b1, '0);
    chk("R11 depth unchanged", {31'b0, ras_valid}, 32'd0);
    stack(1'b1, 1'b1, 32'h0000_0050);
    chk("R11 pair on empty pushes", ras_top, 32'h0000_0050);
    stack(1'b0, 1'b1, '0);
    chk("R11 pair on empty depth one", {31'b0, ras_valid}, 32'd0);

    // R9 overflow
    for (int k = 1; k <= 9; k++) stack(1'b1, 1'b0, 32'(k * 256));
    for (int k = 9; k >= 2; k--) begin
      chk($sformatf("R9 pop order %0d", k), ras_top, 32'(k * 256));
      stack(1'b0, 1'b1, '0);
    end
    chk("R9 empty after eight pops", {31'b0, ras_valid}, 32'd0);
    look(32'h0000_0208, 1'b1);
    chk("R6 return falls back to table", next_pc, 32'h0000_4000);

    // R1 reset again clears table and stack
    stack(1'b1, 1'b0, 32'h0000_0060);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    look(32'h0000_0104, 1'b1);
    chk("R1 table cleared", {31'b0, lk_hit}, 32'd0);
    chk("R1 stack cleared", {31'b0, ras_valid}, 32'd0);

    finish_up();
  end
endmodule